// File: doc/BRIEF.md
# Three-Channel Programmable Sound Generator

This block makes the digital side of a simple chip sound source. There are three square-wave tone channels and one pseudo-random noise source. A per-channel mixer gates each channel by its tone, its noise, or both. Each channel then gives out a 4-bit amplitude code, taken either from its own fixed volume or from a shared envelope generator. The envelope can ramp up or down, once or over and over, and can hold its level at the end of a ramp.

A host sets the block up through sixteen 8-bit registers on a narrow bus. The host first latches a register number and then writes or reads data at that number. One register acts as an 8-bit general-purpose port: it either samples external pins or drives them. All counters advance on a common tick, which a parameterised prescaler takes from the clock. The three amplitude codes go to external converters for mixing.

Top module: `tri_tone_synth`

## Requirements
- R1: When `bus_latch` is high, the low 4 bits of `bus_wdata` become the selected register number. When `bus_we` is high and `bus_latch` is low, `bus_wdata` is stored into the selected register. `bus_rdata` always shows the selected register. Bits beyond a field's width are stored and read as 0: registers 1, 3, 5 and 13 keep 4 bits, and registers 6, 8, 9 and 10 keep 5 bits.
- R2: The tone period of channel A, B or C is N = 256 * (register 1, 3 or 5) + (register 0, 2 or 4) ticks. The channel's square wave changes level every N ticks.
- R3: A tone, noise or envelope period of 0 behaves as a period of 1.
- R4: Noise is bit 0 of a 17-bit shift register. The register is seeded to 1 at reset. It shifts right once every (register 6) ticks, and bit 0 XOR bit 3 enters at bit 16.
- R5: In register 7, bits 0..2 disable the tone of channels A..C and bits 3..5 disable their noise (1 = disabled). A channel is high when (tone high or tone disabled) and (noise high or noise disabled). Its amplitude code is 0 whenever the channel is low.
- R6: In volume registers 8..10, bit 4 = 0 makes the code of a high channel equal bits 3..0. Bit 4 = 1 makes it follow the envelope level, and bits 3..0 are then ignored.
- R7: The envelope steps once every 256 * (register 12) + (register 11) ticks. A write to register 13 restarts the envelope on that edge. The level starts at 0 if shape bit 2 (attack) is 1 and at 15 otherwise, and it then moves one step per period toward the far end.
- R8: If shape bit 3 (continue) is 0, the step after the level reaches the far end sets the level to 0, and it stays there.
- R9: If continue is 1 and shape bit 0 (hold) is 1, the step after the far end leaves the level where it is. If shape bit 1 (alternate) is also 1, that step sets the level to the opposite end instead. The level then stays fixed.
- R10: If continue is 1 and hold is 0, the step after the far end does one of two things. With alternate = 0 the level jumps back to the starting end, which gives a 16-step sawtooth. With alternate = 1 the direction reverses and the level moves one step, which gives a 30-step triangle.
- R11: Register 7 bit 6 sets the port direction. With 1, `port_oe` is 1, `port_out` drives the stored register 14 byte, and reads of register 14 return that byte. With 0, `port_oe` is 0 and reads of register 14 return `port_in`.
- R12: After reset, all registers are 0, the selected register is 0, every amplitude code is 0 and `port_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_latch | input | 1 | Take the register number from `bus_wdata[3:0]` |
| bus_we | input | 1 | Write `bus_wdata` into the selected register |
| bus_wdata | input | 8 | Register number or write data |
| bus_rdata | output | 8 | Contents of the selected register |
| port_in | input | 8 | External pin levels for input mode |
| port_out | output | 8 | Pin drive value for output mode |
| port_oe | output | 1 | Pin drive enable (1 = output) |
| amp_a | output | 4 | Amplitude code, channel A |
| amp_b | output | 4 | Amplitude code, channel B |
| amp_c | output | 4 | Amplitude code, channel C |

## Verification
The bench builds the block with TICK_DIV = 1, so every clock is a tick. This puts full 16-level ramps, 30-step triangles and whole runs of the noise register within a few hundred cycles. It also lets a coarse tone period above 256 be timed in one measurement. The default LFSR_W = 17 and LFSR_TAP = 3 are kept, so the bench's own model of the shift register follows the sequence stated in R4.

// File: rtl/tts_pkg.sv
package tts_pkg;
   localparam int NREG       = 16;
   localparam int NUM_CH     = 3;
   localparam int AMP_W      = 4;
   localparam int TONE_W     = 12;
   localparam int NOISE_W    = 5;
   localparam int ENV_W      = 16;

   localparam logic [3:0] REG_NOISE   = 4'd6;
   localparam logic [3:0] REG_MIXER   = 4'd7;
   localparam logic [3:0] REG_VOL0    = 4'd8;
   localparam logic [3:0] REG_EFINE   = 4'd11;
   localparam logic [3:0] REG_ECOARSE = 4'd12;
   localparam logic [3:0] REG_SHAPE   = 4'd13;
   localparam logic [3:0] REG_PORT    = 4'd14;

   typedef struct packed {
      logic cont;
      logic attack;
      logic alt;
      logic hold;
   } env_shape_t;

   function automatic logic [7:0] reg_mask(input logic [3:0] a);
      case (a)
         4'd1, 4'd3, 4'd5, 4'd13: reg_mask = 8'h0F;
         4'd6, 4'd8, 4'd9, 4'd10: reg_mask = 8'h1F;
         default:                 reg_mask = 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/tts_regfile.sv
module tts_regfile
   import tts_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_latch,
   input  logic                  bus_we,
   input  logic [7:0]            bus_wdata,
   input  logic [7:0]            port_in,
   output logic [7:0]            bus_rdata,
   output logic [NREG-1:0][7:0]  regs_o,
   output logic [3:0]            addr_o,
   output logic                  shape_wr_o
);
   logic [3:0]           addr_q;
   logic [NREG-1:0][7:0] regs_q;
   logic                 wr_en;

   assign wr_en = bus_we && !bus_latch;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         regs_q <= '0;
      end else if (bus_latch) begin
         addr_q <= bus_wdata[3:0];
      end else if (bus_we) begin
         regs_q[addr_q] <= bus_wdata & reg_mask(addr_q);
      end
   end

   always_comb begin
      if (addr_q == REG_PORT && !regs_q[REG_MIXER][6])
         bus_rdata = port_in;
      else
         bus_rdata = regs_q[addr_q];
   end

   assign regs_o     = regs_q;
   assign addr_o     = addr_q;
   assign shape_wr_o = wr_en && (addr_q == REG_SHAPE);
endmodule

// File: rtl/tts_divider.sv
module tts_divider #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clear,
   input  logic [CNT_W-1:0] period,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] eff;
   logic [CNT_W:0]   nxt;

   assign eff  = (period == '0) ? CNT_W'(1) : period;
   assign nxt  = {1'b0, cnt_q} + 1'b1;
   assign wrap = tick && (nxt >= {1'b0, eff});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clear) cnt_q <= '0;
      else if (tick)  cnt_q <= wrap ? '0 : nxt[CNT_W-1:0];
   end
endmodule

// File: rtl/tts_noise.sv
module tts_noise
   import tts_pkg::*;
#(
   parameter int LFSR_W   = 17,
   parameter int LFSR_TAP = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [NOISE_W-1:0] period,
   output logic               noise,
   output logic [LFSR_W-1:0]  state
);
   logic             step;
   logic [LFSR_W-1:0] sr_q;

   tts_divider #(.CNT_W(NOISE_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clear(1'b0),
      .period(period), .wrap(step)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sr_q <= LFSR_W'(1);
      else if (step) sr_q <= {sr_q[0] ^ sr_q[LFSR_TAP], sr_q[LFSR_W-1:1]};
   end

   assign noise = sr_q[0];
   assign state = sr_q;
endmodule

// File: rtl/tts_envelope.sv
module tts_envelope
   import tts_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [ENV_W-1:0] period,
   input  logic             restart,
   input  env_shape_t       shape_in,
   output logic [AMP_W-1:0] level
);
   localparam logic [AMP_W-1:0] TOP = '1;

   logic             step;
   env_shape_t       shape_q;
   logic [AMP_W-1:0] lvl_q;
   logic             up_q;
   logic             idle_q;
   logic             at_end;

   tts_divider #(.CNT_W(ENV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clear(restart),
      .period(period), .wrap(step)
   );

   assign at_end = up_q ? (lvl_q == TOP) : (lvl_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shape_q <= '0;
         lvl_q   <= '0;
         up_q    <= 1'b0;
         idle_q  <= 1'b1;
      end else if (restart) begin
         shape_q <= shape_in;
         lvl_q   <= shape_in.attack ? '0 : TOP;
         up_q    <= shape_in.attack;
         idle_q  <= 1'b0;
      end else if (step && !idle_q) begin
         if (!at_end) begin
            lvl_q <= up_q ? lvl_q + 1'b1 : lvl_q - 1'b1;
         end else if (!shape_q.cont) begin
            lvl_q  <= '0;
            idle_q <= 1'b1;
         end else if (shape_q.hold) begin
            if (shape_q.alt) lvl_q <= ~lvl_q;
            idle_q <= 1'b1;
         end else if (shape_q.alt) begin
            up_q  <= !up_q;
            lvl_q <= up_q ? lvl_q - 1'b1 : lvl_q + 1'b1;
         end else begin
            lvl_q <= up_q ? '0 : TOP;
         end
      end
   end

   assign level = lvl_q;
endmodule

// File: rtl/tri_tone_synth.sv
module tri_tone_synth
   import tts_pkg::*;
#(
   parameter int TICK_DIV = 16,
   parameter int LFSR_W   = 17,
   parameter int LFSR_TAP = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_latch,
   input  logic       bus_we,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic [7:0] port_in,
   output logic [7:0] port_out,
   output logic       port_oe,
   output logic [3:0] amp_a,
   output logic [3:0] amp_b,
   output logic [3:0] amp_c
);
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end
   if (LFSR_TAP < 1 || LFSR_TAP >= LFSR_W) begin : g_bad_tap
      $error("LFSR_TAP must lie inside the shift register");
   end

   logic [NREG-1:0][7:0]         regs;
   logic [3:0]                   addr_q;
   logic                         env_restart;
   logic                         tick;
   logic                         noise;
   logic [LFSR_W-1:0]            noise_state;
   logic [AMP_W-1:0]             env_level;
   logic [NUM_CH-1:0]            tone_q;
   logic [NUM_CH-1:0][AMP_W-1:0] amp;
   logic                         unused_bits;

   tts_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .bus_latch(bus_latch), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .port_in(port_in), .bus_rdata(bus_rdata),
      .regs_o(regs), .addr_o(addr_q), .shape_wr_o(env_restart)
   );

   if (TICK_DIV == 1) begin : g_tick_every
      assign tick = 1'b1;
   end else begin : g_tick_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      assign tick = (pre_q == PW'(TICK_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    pre_q <= '0;
         else if (tick) pre_q <= '0;
         else           pre_q <= pre_q + 1'b1;
      end
   end

   tts_noise #(.LFSR_W(LFSR_W), .LFSR_TAP(LFSR_TAP)) u_noise (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .period(regs[REG_NOISE][NOISE_W-1:0]),
      .noise(noise), .state(noise_state)
   );

   tts_envelope u_env (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .period({regs[REG_ECOARSE], regs[REG_EFINE]}),
      .restart(env_restart), .shape_in(env_shape_t'(bus_wdata[3:0])),
      .level(env_level)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic             tone_wrap;
      logic             ch_high;
      logic [7:0]       vol;

      tts_divider #(.CNT_W(TONE_W)) u_div (
         .clk(clk), .rst_n(rst_n), .tick(tick), .clear(1'b0),
         .period({regs[2*i+1][3:0], regs[2*i]}), .wrap(tone_wrap)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         tone_q[i] <= 1'b0;
         else if (tone_wrap) tone_q[i] <= !tone_q[i];
      end

      assign vol     = regs[int'(REG_VOL0) + i];
      assign ch_high = (tone_q[i] | regs[REG_MIXER][i])
                     & (noise | regs[REG_MIXER][i+3]);
      assign amp[i]  = !ch_high ? '0 : (vol[4] ? env_level : vol[3:0]);
   end

   assign amp_a       = amp[0];
   assign amp_b       = amp[1];
   assign amp_c       = amp[2];
   assign port_out    = regs[REG_PORT];
   assign port_oe     = regs[REG_MIXER][6];
   assign unused_bits = ^{regs, noise_state};
endmodule

// File: rtl/tts_checker.sv
module tts_checker #(
   parameter int LFSR_W = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_latch,
   input logic              bus_we,
   input logic [7:0]        bus_wdata,
   input logic [7:0]        bus_rdata,
   input logic [3:0]        addr_q,
   input logic              env_restart,
   input logic [3:0]        env_level,
   input logic [LFSR_W-1:0] lfsr,
   input logic              port_oe
);
   assert_write_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_latch && addr_q == 4'd0) |=> (bus_rdata == $past(bus_wdata)));

   assert_env_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      env_restart |=> (env_level == ($past(bus_wdata[2]) ? 4'd0 : 4'd15)));

   // R8 R9 R10: the level never moves by more than one step, counted modulo 16
   assert_env_unit_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !env_restart |=> (4'(env_level - $past(env_level)) inside {4'd0, 4'd1, 4'd15}));

   assert_port_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && !bus_latch && addr_q == 4'd7) |=> (port_oe == $past(bus_wdata[6])));

   assert_lfsr_alive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);
endmodule

bind tri_tone_synth tts_checker #(.LFSR_W(LFSR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_latch(bus_latch), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .addr_q(addr_q),
   .env_restart(env_restart), .env_level(env_level), .lfsr(noise_state),
   .port_oe(port_oe)
);

// File: tb/tri_tone_synth_test.sv
`timescale 1ns/1ps
module tri_tone_synth_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_latch = 1'b0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] port_in = 8'h3C;
   logic [7:0] port_out;
   logic       port_oe;
   logic [3:0] amp_a, amp_b, amp_c;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tri_tone_synth #(.TICK_DIV(1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_latch(bus_latch), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .port_in(port_in),
      .port_out(port_out), .port_oe(port_oe),
      .amp_a(amp_a), .amp_b(amp_b), .amp_c(amp_c)
   );

   // {register, write data, expected read}
   localparam logic [19:0] VEC [0:10] = '{
      {4'd0,  8'hA5, 8'hA5}, {4'd1,  8'hFF, 8'h0F}, {4'd3,  8'hE7, 8'h07},
      {4'd6,  8'hFF, 8'h1F}, {4'd8,  8'hFF, 8'h1F}, {4'd10, 8'h35, 8'h15},
      {4'd12, 8'hC4, 8'hC4}, {4'd13, 8'hF9, 8'h09}, {4'd14, 8'h99, 8'h3C},
      {4'd15, 8'h5A, 8'h5A}, {4'd7,  8'h00, 8'h00}
   };

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic latch(input logic [3:0] a);
      @(negedge clk); bus_latch = 1'b1; bus_wdata = {4'h0, a};
      @(negedge clk); bus_latch = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      latch(a);
      bus_we = 1'b1; bus_wdata = d;
      @(negedge clk); bus_we = 1'b0;
   endtask

   function automatic int amp_of(input int ch);
      return (ch == 0) ? int'(amp_a) : (ch == 1) ? int'(amp_b) : int'(amp_c);
   endfunction

   task automatic interval(input int ch, output int n);
      int v0, w;
      v0 = amp_of(ch); w = 0;
      while (amp_of(ch) == v0 && w < 2000) begin @(negedge clk); w++; end
      v0 = amp_of(ch); n = 0;
      while (amp_of(ch) == v0 && n < 2000) begin @(negedge clk); n++; end
   endtask

   function automatic int env_expect(input logic [3:0] s, input int k);
      bit c, a, al, h;
      int m, t;
      {c, a, al, h} = s;
      if (k <= 15) return a ? k : 15 - k;
      if (!c) return 0;
      if (h) return al ? (a ? 0 : 15) : (a ? 15 : 0);
      if (al) begin
         m = k % 30; t = (m <= 15) ? m : 30 - m;
         return a ? t : 15 - t;
      end
      m = k % 16;
      return a ? m : 15 - m;
   endfunction

   task automatic env_run(input logic [3:0] s, input int per, input string req);
      int bad;
      bad = 0;
      wr(4'd13, {4'h0, s});
      for (int k = 0; k < 48; k++) begin
         if (int'(amp_c) != env_expect(s, k / per)) bad++;
         @(negedge clk);
      end
      chk(req, bad, 0);
   endtask

   task automatic noise_run(input int stride, input string req);
      logic [16:0] s;
      int w, bad;
      int v0;
      w = 0; v0 = int'(amp_a);
      while (int'(amp_a) == v0 && w < 500) begin @(negedge clk); w++; end
      chk({req, " noise activity"}, int'(w < 500), 1);
      for (int j = 0; j < 17; j++) begin
         s[j] = (amp_a != 0);
         repeat (stride) @(negedge clk);
      end
      for (int j = 0; j < 17; j++) s = {s[0] ^ s[3], s[16:1]};
      bad = 0;
      for (int j = 0; j < 30; j++) begin
         if ((amp_a != 0) != s[0]) bad++;
         s = {s[0] ^ s[3], s[16:1]};
         repeat (stride) @(negedge clk);
      end
      chk(req, bad, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int n, bad;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 amp_a", amp_a, 0);
      chk("R12 amp_b", amp_b, 0);
      chk("R12 amp_c", amp_c, 0);
      chk("R12 port_oe", port_oe, 0);
      chk("R12 rdata", bus_rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 amp after release", amp_of(0) + amp_of(1) + amp_of(2), 0);

      // R1 masked write and readback, table driven
      foreach (VEC[i]) begin
         wr(VEC[i][19:16], VEC[i][15:8]);
         chk($sformatf("R1 reg %0d", VEC[i][19:16]), bus_rdata, VEC[i][7:0]);
      end
      // R11 input mode already seen at entry 8; switch to output
      wr(4'd7, 8'h40);
      chk("R11 port_oe", port_oe, 1);
      chk("R11 port_out", port_out, 8'h99);
      latch(4'd14);
      chk("R11 read output byte", bus_rdata, 8'h99);
      wr(4'd7, 8'h00);
      latch(4'd14);
      chk("R11 read pins", bus_rdata, 8'h3C);
      chk("R11 port_oe off", port_oe, 0);
      // R1 repeated writes go to the last latched register
      latch(4'd2);
      bus_we = 1'b1; bus_wdata = 8'h11; @(negedge clk);
      bus_wdata = 8'h22; @(negedge clk); bus_we = 1'b0;
      chk("R1 second write", bus_rdata, 8'h22);

      // clear periods used above
      wr(4'd1, 8'h00); wr(4'd3, 8'h00); wr(4'd2, 8'h00);

      // R2 R3 tone timing on channel A, tones only
      wr(4'd7, 8'h38); wr(4'd8, 8'h09);
      wr(4'd0, 8'h03);
      interval(0, n); chk("R2 fine period 3", n, 3);
      chk("R5 tone high level", (amp_a == 9 || amp_a == 0), 1);
      wr(4'd0, 8'h00);
      interval(0, n); chk("R3 period zero", n, 1);
      wr(4'd0, 8'h02); wr(4'd1, 8'h01);
      interval(0, n); chk("R2 coarse period", n, 258);

      // R5 everything disabled: constant volume on B
      wr(4'd7, 8'h3F); wr(4'd9, 8'h05);
      bad = 0;
      for (int k = 0; k < 50; k++) begin
         if (amp_b != 4'd5) bad++;
         @(negedge clk);
      end
      chk("R5 all disabled holds volume", bad, 0);

      // R4 noise on channel A only
      wr(4'd9, 8'h00); wr(4'd8, 8'h0F);
      wr(4'd7, 8'h37); wr(4'd6, 8'h00);
      noise_run(1, "R4 stride 1");
      wr(4'd6, 8'h03);
      repeat (4) @(negedge clk);
      noise_run(3, "R4 stride 3");

      // envelope on channel C, all sources disabled
      wr(4'd8, 8'h00); wr(4'd7, 8'h3F);
      wr(4'd10, 8'h0A);
      chk("R6 fixed volume", amp_c, 10);
      wr(4'd10, 8'h1A);
      wr(4'd11, 8'h01); wr(4'd12, 8'h00);
      env_run(4'h0, 1, "R8 fall once");
      env_run(4'h4, 1, "R8 rise once");
      env_run(4'hD, 1, "R9 rise hold");
      env_run(4'hB, 1, "R9 fall alt hold");
      env_run(4'hC, 1, "R10 sawtooth");
      env_run(4'hE, 1, "R10 triangle");
      wr(4'd11, 8'h03);
      env_run(4'hC, 3, "R7 period 3");
      // R7 restart mid ramp
      wr(4'd11, 8'h01);
      wr(4'd13, 8'h08);
      repeat (5) @(negedge clk);
      wr(4'd13, 8'h08);
      chk("R7 restart fall", amp_c, 15);
      wr(4'd13, 8'h0C);
      chk("R7 restart rise", amp_c, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule